// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block moves a CPU from normal execution into an interrupt service routine. A priority resolver hands it one accepted request at a time, made of a level number and a vector-table address. At acceptance the sequencer latches the CPU's program counter, flag byte and stack pointer. It then saves that context through a byte-wide stack-write port, fetches a two-byte service address from a byte-wide vector-table read port, and hands the CPU a new program counter and stack pointer to load.

One interrupt level can instead take a short path. The CPU's mode byte holds an enable bit and a 3-bit level field. When a request's level matches that field and the enable bit is set, the sequencer writes nothing to the stack. The program counter swaps with a 16-bit instruction-pointer register pair held in this block, and the flag byte is copied to a shadow flag register. Both entry paths have fixed lengths, so that software timing can rely on them. Every entry clears the global interrupt enable, and a nested interrupt needs the service routine to set it again.

Top module: `irq_entry_seq`

## Requirements
- R1: On a normal entry the sequencer makes exactly three stack writes, each to an address one below the previous one. The program counter bits 7:0 go to SP-1 first, bits 15:8 go to SP-2 second, and the flag byte goes to SP-3 third. At the final cycle, sp_load pulses with sp_new = SP-3.
- R2: After the three writes, a normal entry reads the vector table twice, first at V (the low 8 bits of the vector address) and then at V+1. The data for each read is expected on vec_rdata in the cycle after vec_re. The new program counter is {byte read at V, byte read at V+1}.
- R3: A normal entry holds busy high for exactly 22 clock cycles. pc_load pulses only in the last of them.
- R4: On the normal path, a vector address is rejected if bits 15:8 are nonzero, if bit 0 is 1, or if it lies in 0x003C to 0x003F. A rejected request gives a one-cycle err pulse in the cycle after the request. busy stays low, and the request causes no stack write, no vector read and no pc_load.
- R5: The fast path is selected when mode_val bit 1 is 1 and mode_val bits 4:2 equal req_level. Every other request takes the normal path.
- R6: A fast entry holds busy high for exactly 6 cycles and makes no stack write, no vector read and no sp_load. Its vector address is not validated. In the last busy cycle, pc_load pulses with pc_new equal to the instruction pointer. The instruction pointer then holds the old program counter, and the shadow flag register holds the flag byte.
- R7: When the sequencer is not completing a fast entry, ip_wr_hi writes ip_wdata into instruction-pointer bits 15:8 and ip_wr_lo writes it into bits 7:0. The result can be read on ip_q.
- R8: While busy is high, requests are ignored. A request made during an entry does not change that entry's accesses or its result, and it does not start a second entry.
- R9: Every accepted entry pulses gie_clr for exactly one cycle, in its first busy cycle.
- R10: After reset, busy, err, gie_clr, pc_load, sp_load, stk_we and vec_re are low, and ip_q and shadow_flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request strobe from the priority resolver |
| req_level | input | 3 | Level of the request |
| req_vec | input | 16 | Vector-table address of the request |
| pc_in | input | 16 | Current CPU program counter |
| flags_in | input | 8 | Current CPU flag byte |
| sp_in | input | 16 | Current CPU stack pointer |
| mode_val | input | 8 | CPU mode byte: bit 1 enables the fast path, bits 4:2 select its level |
| ip_wr_hi | input | 1 | Write the instruction-pointer high byte |
| ip_wr_lo | input | 1 | Write the instruction-pointer low byte |
| ip_wdata | input | 8 | Write data for the instruction pointer |
| ip_q | output | 16 | Instruction-pointer contents |
| shadow_flags | output | 8 | Flag byte saved by the last fast entry |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| vec_re | output | 1 | Vector-table read strobe |
| vec_addr | output | 8 | Vector-table read address |
| vec_rdata | input | 8 | Vector-table read data, valid in the cycle after vec_re |
| busy | output | 1 | An entry is in progress |
| pc_load | output | 1 | CPU loads pc_new this cycle |
| pc_new | output | 16 | New program counter |
| sp_load | output | 1 | CPU loads sp_new this cycle |
| sp_new | output | 16 | New stack pointer |
| gie_clr | output | 1 | Clear the global interrupt enable |
| err | output | 1 | Request rejected for an illegal vector address |

## Verification
The hardest case to reach is a second request arriving in the middle of an entry, with a vector address that would give different reads. The bench starts a normal entry and waits a few cycles. It then pulses a second request, and it checks that only the first vector's two addresses are read, that busy lasts one entry length and that exactly one pc_load occurs. The swap on the fast path is reached by first writing a known value into the instruction pointer through its byte ports. The bench also sends a vector address that is illegal on a fast-level request, to show that the short path skips vector validation.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int PC_W     = 16;
    localparam int DATA_W   = 8;
    localparam int VEC_W    = 16;
    localparam int LVL_W    = 3;
    localparam int TBL_W    = 8;

    // entry lengths in busy cycles
    localparam int NORM_LEN = 22;
    localparam int FAST_LEN = 6;
    localparam int CNT_W    = $clog2(NORM_LEN);

    // action slots of the normal path (counter values)
    localparam int SLOT_PC_LO = 1;
    localparam int SLOT_PC_HI = 4;
    localparam int SLOT_FLG   = 7;
    localparam int SLOT_RD_HI = 10;
    localparam int SLOT_RD_LO = 13;

    // mode byte field positions
    localparam int MODE_EN_BIT  = 1;
    localparam int MODE_LVL_LSB = 2;

    // reserved table window (word-aligned group of four)
    localparam logic [TBL_W-3:0] RSV_GROUP = 6'h0F;

    typedef enum logic [1:0] {ST_IDLE, ST_NORM, ST_FAST} seq_state_e;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [DATA_W-1:0] flags;
        logic [PC_W-1:0]   sp;
        logic [TBL_W-1:0]  vec;
    } entry_ctx_t;

    function automatic logic vec_is_legal(input logic [VEC_W-1:0] v);
        return (v[VEC_W-1:TBL_W] == '0) && !v[0] && (v[TBL_W-1:2] != RSV_GROUP);
    endfunction
endpackage

// File: rtl/irq_req_decode.sv
module irq_req_decode
    import irq_entry_pkg::*;
(
    input  logic [LVL_W-1:0]  level,
    input  logic [VEC_W-1:0]  vec,
    input  logic [DATA_W-1:0] mode,
    output logic              use_fast,
    output logic              vec_ok
);
    always_comb begin
        use_fast = mode[MODE_EN_BIT] &&
                   (mode[MODE_LVL_LSB +: LVL_W] == level);
        vec_ok   = vec_is_legal(vec);
    end
endmodule

// File: rtl/irq_ip_regs.sv
module irq_ip_regs
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              swap_en,
    input  logic [PC_W-1:0]   swap_pc,
    input  logic [DATA_W-1:0] swap_flags,
    output logic [PC_W-1:0]   ip_q,
    output logic [DATA_W-1:0] shadow_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q     <= '0;
            shadow_q <= '0;
        end else if (swap_en) begin
            ip_q     <= swap_pc;
            shadow_q <= swap_flags;
        end else begin
            if (wr_hi) ip_q[PC_W-1:DATA_W] <= wdata;
            if (wr_lo) ip_q[DATA_W-1:0]    <= wdata;
        end
    end
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_fast,
    input  logic              req_ok,
    input  entry_ctx_t        ctx_in,
    input  logic [DATA_W-1:0] vec_rdata,
    output entry_ctx_t        ctx_q,
    output logic              busy,
    output logic              stk_we,
    output logic [PC_W-1:0]   stk_addr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              vec_re,
    output logic [TBL_W-1:0]  vec_addr,
    output logic              pc_load,
    output logic              fast_last,
    output logic [PC_W-1:0]   pc_fetched,
    output logic              sp_load,
    output logic [PC_W-1:0]   sp_new,
    output logic              gie_clr,
    output logic              err
);
    localparam logic [CNT_W-1:0] N_LAST = CNT_W'(NORM_LEN - 1);
    localparam logic [CNT_W-1:0] F_LAST = CNT_W'(FAST_LEN - 1);

    seq_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   byte_hi, byte_lo;
    logic                at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            ctx_q   <= '0;
            byte_hi <= '0;
            byte_lo <= '0;
            err     <= 1'b0;
        end else begin
            err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req_valid) begin
                        if (req_fast) begin
                            state <= ST_FAST;
                            ctx_q <= ctx_in;
                        end else if (req_ok) begin
                            state <= ST_NORM;
                            ctx_q <= ctx_in;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_NORM: begin
                    if (cnt == CNT_W'(SLOT_RD_HI + 1)) byte_hi <= vec_rdata;
                    if (cnt == CNT_W'(SLOT_RD_LO + 1)) byte_lo <= vec_rdata;
                    if (cnt == N_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FAST: begin
                    if (cnt == F_LAST) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        at_last   = ((state == ST_NORM) && (cnt == N_LAST)) ||
                    ((state == ST_FAST) && (cnt == F_LAST));
        pc_load   = at_last;
        fast_last = at_last && (state == ST_FAST);
        sp_load   = at_last && (state == ST_NORM);
        sp_new    = ctx_q.sp - PC_W'(3);
        pc_fetched = {byte_hi, byte_lo};
        gie_clr   = busy && (cnt == '0);

        stk_we    = 1'b0;
        stk_addr  = '0;
        stk_wdata = '0;
        vec_re    = 1'b0;
        vec_addr  = '0;
        if (state == ST_NORM) begin
            if (cnt == CNT_W'(SLOT_PC_LO)) begin
                stk_we    = 1'b1;
                stk_addr  = ctx_q.sp - PC_W'(1);
                stk_wdata = ctx_q.pc[DATA_W-1:0];
            end
            if (cnt == CNT_W'(SLOT_PC_HI)) begin
                stk_we    = 1'b1;
                stk_addr  = ctx_q.sp - PC_W'(2);
                stk_wdata = ctx_q.pc[PC_W-1:DATA_W];
            end
            if (cnt == CNT_W'(SLOT_FLG)) begin
                stk_we    = 1'b1;
                stk_addr  = ctx_q.sp - PC_W'(3);
                stk_wdata = ctx_q.flags;
            end
            if (cnt == CNT_W'(SLOT_RD_HI)) begin
                vec_re   = 1'b1;
                vec_addr = ctx_q.vec;
            end
            if (cnt == CNT_W'(SLOT_RD_LO)) begin
                vec_re   = 1'b1;
                vec_addr = ctx_q.vec | TBL_W'(1);
            end
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [PC_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] mode_val,
    input  logic              ip_wr_hi,
    input  logic              ip_wr_lo,
    input  logic [DATA_W-1:0] ip_wdata,
    output logic [PC_W-1:0]   ip_q,
    output logic [DATA_W-1:0] shadow_flags,
    output logic              stk_we,
    output logic [PC_W-1:0]   stk_addr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              vec_re,
    output logic [TBL_W-1:0]  vec_addr,
    input  logic [DATA_W-1:0] vec_rdata,
    output logic              busy,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_new,
    output logic              sp_load,
    output logic [PC_W-1:0]   sp_new,
    output logic              gie_clr,
    output logic              err
);
    logic       use_fast, vec_ok, fast_last;
    entry_ctx_t ctx_in, ctx_q;
    logic [PC_W-1:0] pc_fetched;

    always_comb begin
        ctx_in.pc    = pc_in;
        ctx_in.flags = flags_in;
        ctx_in.sp    = sp_in;
        ctx_in.vec   = req_vec[TBL_W-1:0];
    end

    irq_req_decode u_dec (
        .level    (req_level),
        .vec      (req_vec),
        .mode     (mode_val),
        .use_fast (use_fast),
        .vec_ok   (vec_ok)
    );

    irq_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_fast   (use_fast),
        .req_ok     (vec_ok),
        .ctx_in     (ctx_in),
        .vec_rdata  (vec_rdata),
        .ctx_q      (ctx_q),
        .busy       (busy),
        .stk_we     (stk_we),
        .stk_addr   (stk_addr),
        .stk_wdata  (stk_wdata),
        .vec_re     (vec_re),
        .vec_addr   (vec_addr),
        .pc_load    (pc_load),
        .fast_last  (fast_last),
        .pc_fetched (pc_fetched),
        .sp_load    (sp_load),
        .sp_new     (sp_new),
        .gie_clr    (gie_clr),
        .err        (err)
    );

    irq_ip_regs u_ip (
        .clk        (clk),
        .rst        (rst),
        .wr_hi      (ip_wr_hi),
        .wr_lo      (ip_wr_lo),
        .wdata      (ip_wdata),
        .swap_en    (fast_last),
        .swap_pc    (ctx_q.pc),
        .swap_flags (ctx_q.flags),
        .ip_q       (ip_q),
        .shadow_q   (shadow_flags)
    );

    assign pc_new = fast_last ? ip_q : pc_fetched;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
    import irq_entry_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             err,
    input logic             gie_clr,
    input logic             pc_load,
    input logic             sp_load,
    input logic             stk_we,
    input logic             vec_re,
    input logic [TBL_W-1:0] vec_addr
);
    logic [CNT_W:0] run;

    always_ff @(posedge clk) begin
        if (rst || !busy) run <= '0;
        else              run <= run + 1'b1;
    end

    // R4: a rejected request never starts an entry
    a_r4_err_idle: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    // R4: the reserved table window is never read
    a_r4_no_rsv_read: assert property (@(posedge clk) disable iff (rst)
        vec_re |-> (vec_addr[TBL_W-1:2] != RSV_GROUP));

    // R1: stack writes only occur inside an entry
    a_r1_stk_in_entry: assert property (@(posedge clk) disable iff (rst)
        stk_we |-> busy);

    // R3 / R6: the load ends the entry after an exact length
    a_r3_load_len: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> (run == (CNT_W+1)'(NORM_LEN - 1) ||
                     run == (CNT_W+1)'(FAST_LEN - 1)));

    a_r3_load_ends: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy);

    // R6: sp_load only comes with a pc_load
    a_r6_sp_with_pc: assert property (@(posedge clk) disable iff (rst)
        sp_load |-> pc_load);

    // R9: every entry starts by clearing the global enable
    a_r9_gie_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> gie_clr);
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .err      (err),
    .gie_clr  (gie_clr),
    .pc_load  (pc_load),
    .sp_load  (sp_load),
    .stk_we   (stk_we),
    .vec_re   (vec_re),
    .vec_addr (vec_addr)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_level;
    logic [15:0] req_vec, pc_in, sp_in;
    logic [7:0]  flags_in, mode_val, ip_wdata, vec_rdata;
    logic        ip_wr_hi, ip_wr_lo;
    logic [15:0] ip_q, stk_addr, pc_new, sp_new;
    logic [7:0]  shadow_flags, stk_wdata, vec_addr;
    logic        stk_we, vec_re, busy, pc_load, sp_load, gie_clr, err;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // monitors
    int          n_wr, n_rd, busy_cyc, n_load, n_spld, n_gie, n_err;
    logic [15:0] wr_addr [4];
    logic [7:0]  wr_data [4];
    logic [7:0]  rd_addr [4];
    logic [15:0] load_pc, spld_val;

    always #4 clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .req_vec(req_vec), .pc_in(pc_in), .flags_in(flags_in), .sp_in(sp_in),
        .mode_val(mode_val), .ip_wr_hi(ip_wr_hi), .ip_wr_lo(ip_wr_lo),
        .ip_wdata(ip_wdata), .ip_q(ip_q), .shadow_flags(shadow_flags),
        .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .vec_re(vec_re), .vec_addr(vec_addr), .vec_rdata(vec_rdata),
        .busy(busy), .pc_load(pc_load), .pc_new(pc_new), .sp_load(sp_load),
        .sp_new(sp_new), .gie_clr(gie_clr), .err(err)
    );

    function automatic logic [7:0] vmem(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'h5A;
    endfunction

    // vector table model: data one cycle after the read strobe
    always @(posedge clk) begin
        if (vec_re) vec_rdata <= vmem(vec_addr);
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (stk_we) begin
                if (n_wr < 4) begin
                    wr_addr[n_wr] = stk_addr;
                    wr_data[n_wr] = stk_wdata;
                end
                n_wr = n_wr + 1;
            end
            if (vec_re) begin
                if (n_rd < 4) rd_addr[n_rd] = vec_addr;
                n_rd = n_rd + 1;
            end
            if (busy)    busy_cyc = busy_cyc + 1;
            if (pc_load) begin n_load = n_load + 1; load_pc = pc_new; end
            if (sp_load) begin n_spld = n_spld + 1; spld_val = sp_new; end
            if (gie_clr) n_gie = n_gie + 1;
            if (err)     n_err = n_err + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 100000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic clr_mon();
        n_wr = 0; n_rd = 0; busy_cyc = 0; n_load = 0; n_spld = 0;
        n_gie = 0; n_err = 0; load_pc = '0; spld_val = '0;
        for (int i = 0; i < 4; i++) begin
            wr_addr[i] = '0; wr_data[i] = '0; rd_addr[i] = '0;
        end
    endtask

    task automatic fire(input logic [2:0] lvl, input logic [15:0] v,
                        input logic [15:0] pc, input logic [7:0] fl, input logic [15:0] sp);
        @(negedge clk);
        clr_mon();
        req_valid = 1'b1; req_level = lvl; req_vec = v;
        pc_in = pc; flags_in = fl; sp_in = sp;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
    endtask

    task automatic ip_write(input logic [15:0] val);
        @(negedge clk);
        ip_wr_hi = 1'b1; ip_wdata = val[15:8];
        @(negedge clk);
        ip_wr_hi = 1'b0; ip_wr_lo = 1'b1; ip_wdata = val[7:0];
        @(negedge clk);
        ip_wr_lo = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 busy", {31'b0, busy}, 0);
        chk("R10 strobes", {26'b0, err, gie_clr, pc_load, sp_load, stk_we, vec_re}, 0);
        chk("R10 ip", {16'b0, ip_q}, 0);
        chk("R10 shadow", {24'b0, shadow_flags}, 0);
    endtask

    task automatic t_normal(input string nm, input logic [2:0] lvl, input logic [15:0] v,
                            input logic [15:0] pc, input logic [7:0] fl, input logic [15:0] sp);
        logic [7:0] vb;
        vb = v[7:0];
        fire(lvl, v, pc, fl, sp);
        chk({nm, " R1 nwr"}, n_wr, 3);
        chk({nm, " R1 a0"}, {16'b0, wr_addr[0]}, {16'b0, sp - 16'd1});
        chk({nm, " R1 d0"}, {24'b0, wr_data[0]}, {24'b0, pc[7:0]});
        chk({nm, " R1 a1"}, {16'b0, wr_addr[1]}, {16'b0, sp - 16'd2});
        chk({nm, " R1 d1"}, {24'b0, wr_data[1]}, {24'b0, pc[15:8]});
        chk({nm, " R1 a2"}, {16'b0, wr_addr[2]}, {16'b0, sp - 16'd3});
        chk({nm, " R1 d2"}, {24'b0, wr_data[2]}, {24'b0, fl});
        chk({nm, " R1 sp"}, {n_spld[15:0], spld_val}, {16'd1, sp - 16'd3});
        chk({nm, " R2 nrd"}, n_rd, 2);
        chk({nm, " R2 r0"}, {24'b0, rd_addr[0]}, {24'b0, vb});
        chk({nm, " R2 r1"}, {24'b0, rd_addr[1]}, {24'b0, vb + 8'd1});
        chk({nm, " R2 pc"}, {16'b0, load_pc}, {16'b0, vmem(vb), vmem(vb + 8'd1)});
        chk({nm, " R3 len"}, busy_cyc, 22);
        chk({nm, " R3 loads"}, n_load, 1);
        chk({nm, " R9 gie"}, n_gie, 1);
        chk({nm, " R4 noerr"}, n_err, 0);
    endtask

    task automatic t_bad(input logic [15:0] v);
        fire(3'd1, v, 16'h4444, 8'h11, 16'h0200);
        chk("R4 err", n_err, 1);
        chk("R4 nobusy", busy_cyc, 0);
        chk("R4 noacc", n_wr + n_rd + n_load, 0);
    endtask

    task automatic t_fast(input logic [15:0] ipv, input logic [15:0] v);
        mode_val = 8'h16;   // enable, level 5
        ip_write(ipv);
        chk("R7 ip write", {16'b0, ip_q}, {16'b0, ipv});
        fire(3'd5, v, 16'h1234, 8'hA5, 16'h0300);
        chk("R6 len", busy_cyc, 6);
        chk("R6 nostk", n_wr + n_rd + n_spld, 0);
        chk("R6 noerr", n_err, 0);
        chk("R6 pc", {n_load[15:0], load_pc}, {16'd1, ipv});
        chk("R6 ip swap", {16'b0, ip_q}, 32'h1234);
        chk("R6 shadow", {24'b0, shadow_flags}, 32'hA5);
        chk("R9 gie fast", n_gie, 1);
    endtask

    task automatic t_ignore();
        mode_val = 8'h00;
        @(negedge clk);
        clr_mon();
        req_valid = 1'b1; req_level = 3'd2; req_vec = 16'h0020;
        pc_in = 16'hABCD; flags_in = 8'h3C; sp_in = 16'h0400;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_vec = 16'h0080; pc_in = 16'h9999; sp_in = 16'h0800;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 len", busy_cyc, 22);
        chk("R8 loads", n_load, 1);
        chk("R8 r0", {24'b0, rd_addr[0]}, 32'h20);
        chk("R8 r1", {24'b0, rd_addr[1]}, 32'h21);
        chk("R8 a0", {16'b0, wr_addr[0]}, 32'h03FF);
        chk("R8 pc", {16'b0, load_pc}, {16'b0, vmem(8'h20), vmem(8'h21)});
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_level = '0; req_vec = '0;
        pc_in = '0; flags_in = '0; sp_in = '0; mode_val = '0;
        ip_wr_hi = 1'b0; ip_wr_lo = 1'b0; ip_wdata = '0; vec_rdata = '0;
        clr_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();

        t_normal("n1", 3'd0, 16'h0010, 16'h1357, 8'hC4, 16'h0100);
        t_normal("n2 top", 3'd7, 16'h00FE, 16'hFFFF, 8'h00, 16'h8000);
        t_normal("n3 below rsv", 3'd3, 16'h003A, 16'h0001, 8'hFF, 16'h0003);
        t_normal("n4 above rsv", 3'd4, 16'h0040, 16'h8421, 8'h5A, 16'h1000);

        t_bad(16'h0007);
        t_bad(16'h0100);
        t_bad(16'h003C);
        t_bad(16'h003E);

        t_fast(16'hBEEF, 16'h0007);  // odd vector ignored on fast path

        mode_val = 8'h14;            // R5: level 5 but enable bit clear
        t_normal("R5 dis", 3'd5, 16'h0050, 16'h2222, 8'h81, 16'h0500);
        chk("R5 dis ip kept", {16'b0, ip_q}, 32'h1234);
        mode_val = 8'h16;            // R5: enabled for level 5, request level 3
        t_normal("R5 other lvl", 3'd3, 16'h0060, 16'h3333, 8'h42, 16'h0600);

        t_ignore();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule